// File: doc/BRIEF.md
# Response Status Parity Checker

This block watches a shared system bus. The agent that completes a transaction drives a 3-line, active-low response status code, plus one parity line that covers those three lines. On every bus clock the checker registers the status and parity lines once. It then decides whether a response is on the bus and compares the parity line with the value it should have. A mismatch produces a one-cycle error strobe. The first offending code is captured, and a saturating counter keeps track of how many errors were seen.

The parity rule counts lines that are low, which means asserted. An even number of low lines needs the parity line high. An odd number needs it low. When every status line is high, the bus is idle: no agent is driving a response, so nobody guarantees parity. The idle case is therefore never flagged as an error. If the parity line is seen low while the bus is idle, the block raises a separate warning strobe instead.

The captured code is reported in logical form, where bit i is 1 when status line i is low. Because of this, a reading of zero means no error has been captured. A single error output is the block's only link to wider machine-check handling.

Top module: `rsp_par_checker`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets synchronously. After that edge err_o and idle_warn_o are 0, err_code_o is 0 and err_cnt_o is 0.
- R2: A response is present when at least one line of stat_n_i is low. If par_i is high for an even number of low lines, or low for an odd number, err_o stays 0.
- R3: A response whose par_i does not match the rule in R2 drives err_o high for exactly one clock. The pulse starts in the cycle right after the cycle in which the inputs were sampled.
- R4: When all lines of stat_n_i are high (idle), err_o stays 0 whatever the level of par_i.
- R5: An idle cycle with par_i low drives idle_warn_o high for one clock, with the same latency as R3. An idle cycle with par_i high raises no warning, and a cycle with a response present never raises one.
- R6: When err_o is high and err_code_o reads 0, the next edge loads err_code_o with the logical code of the failing response (bit i = inverse of stat_n_i line i). While err_code_o is non-zero and clr_i is low, later errors leave it unchanged.
- R7: With clr_i high at an edge, err_code_o reads 0 after that edge. The exception is when err_o is also high in that cycle: then the failing code is loaded instead.
- R8: Each cycle with err_o high adds one to err_cnt_o at the next edge. At the all-ones value of its CNT_W bits, the counter holds.
- R9: Asserting rst_n in the middle of a run returns err_code_o and err_cnt_o to 0, whatever they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stat_n_i | input | STAT_W | Response status lines, active low |
| par_i | input | 1 | Parity line covering stat_n_i |
| clr_i | input | 1 | Clears the captured error code |
| err_o | output | 1 | One-cycle parity error strobe |
| idle_warn_o | output | 1 | One-cycle strobe: parity line low while the bus is idle |
| err_code_o | output | STAT_W | First captured failing code in logical form, 0 when empty |
| err_cnt_o | output | CNT_W | Saturating count of parity errors |

## Verification
The bench keeps STAT_W at its default of 3, so it can try all eight status patterns with both correct and inverted parity. It narrows CNT_W to 4, which makes the counter saturate at 15 after a short burst of bad responses. That lets the hold-at-maximum behaviour, and the increment step just before it, be observed within a few dozen cycles instead of hundreds.

// File: rtl/rsp_par_pkg.sv
// Package: shared types for the response status parity checker.
// Assumes: status lines are active low and the idle code is all lines high.
package rsp_par_pkg;

    // Per-cycle verdict produced by the evaluator from registered lines
    typedef struct packed {
        logic present;   // at least one status line asserted
        logic mismatch;  // response present with wrong parity
        logic idle_low;  // idle bus while parity line reads low
    } chk_flags_t;

endpackage

// File: rtl/rsp_par_sampler.sv
// Module: input register stage.
// Registers every status line and the parity line once, so that the
// checks downstream work on values held steady for a full clock.
// Assumes: reset state equals the idle bus (all lines high, parity high).
module rsp_par_sampler #(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_n_i,
    input  logic              par_i,
    output logic [STAT_W-1:0] stat_n_q,
    output logic              par_q
);

    // One flop per status line, each reset to the released (high) level
    for (genvar g = 0; g < STAT_W; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) stat_n_q[g] <= 1'b1;
            else        stat_n_q[g] <= stat_n_i[g];
        end
    end

    // Parity flop, reset to the level of an undriven parity line
    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= 1'b1;
        else        par_q <= par_i;
    end

endmodule

// File: rtl/rsp_par_eval.sv
// Module: combinational evaluator.
// Counts the asserted (low) status lines and derives the expected parity:
// high for an even count, low for an odd one. A response is present when
// any line is low. Idle cycles are never checked and only produce a flag
// when the parity line is low.
// Assumes: inputs come from the register stage.
module rsp_par_eval
    import rsp_par_pkg::*;
#(
    parameter int STAT_W = 3
) (
    input  logic [STAT_W-1:0] stat_n_q,
    input  logic              par_q,
    output chk_flags_t        flags_o,
    output logic [STAT_W-1:0] code_o
);

    logic odd_lows;
    logic exp_par;

    // Toggle once per asserted line to get the parity of the low count
    always_comb begin
        odd_lows = 1'b0;
        for (int i = 0; i < STAT_W; i++) begin
            if (!stat_n_q[i]) odd_lows = ~odd_lows;
        end
    end

    // Form the verdict flags and the logical code of this cycle
    always_comb begin
        exp_par          = ~odd_lows;
        code_o           = ~stat_n_q;
        flags_o.present  = ~(&stat_n_q);
        flags_o.mismatch = flags_o.present & (par_q != exp_par);
        flags_o.idle_low = ~flags_o.present & ~par_q;
    end

endmodule

// File: rtl/rsp_par_log.sv
// Module: error record.
// Keeps the first failing code until cleared, and a saturating count of
// errors. A clear that coincides with an error loads the new code.
// Assumes: err_i is a one-cycle strobe; code 0 cannot fail (it is idle).
module rsp_par_log #(
    parameter int STAT_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_i,
    input  logic [STAT_W-1:0] code_i,
    input  logic              clr_i,
    output logic [STAT_W-1:0] code_q,
    output logic [CNT_W-1:0]  cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic slot_free;
    assign slot_free = (code_q == '0) || clr_i;

    // Capture register: load into a free slot, otherwise obey clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 code_q <= '0;
        else if (err_i && slot_free) code_q <= code_i;
        else if (clr_i)             code_q <= '0;
    end

    // Saturating error counter
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (err_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
    end

    p_code_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && code_q == '0) |=> (code_q == $past(code_i)));

    p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0 && !clr_i) |=> $stable(code_q));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !err_i) |=> (code_q == '0));

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/rsp_par_checker.sv
// Module: top of the response status parity checker.
// Register stage -> evaluator -> error record. err_o and idle_warn_o
// appear one clock after the inputs are sampled. Record updates land
// one clock later.
// Assumes: clr_i is synchronous to clk and acts at the edge it is seen.
module rsp_par_checker
    import rsp_par_pkg::*;
#(
    parameter int STAT_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_n_i,
    input  logic              par_i,
    input  logic              clr_i,
    output logic              err_o,
    output logic              idle_warn_o,
    output logic [STAT_W-1:0] err_code_o,
    output logic [CNT_W-1:0]  err_cnt_o
);

    logic [STAT_W-1:0] stat_n_q;
    logic              par_q;
    chk_flags_t        flags;
    logic [STAT_W-1:0] cur_code;

    rsp_par_sampler #(.STAT_W(STAT_W)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_n_i (stat_n_i),
        .par_i    (par_i),
        .stat_n_q (stat_n_q),
        .par_q    (par_q)
    );

    rsp_par_eval #(.STAT_W(STAT_W)) u_eval (
        .stat_n_q (stat_n_q),
        .par_q    (par_q),
        .flags_o  (flags),
        .code_o   (cur_code)
    );

    // Strobes straight from the verdict of the registered cycle
    assign err_o       = flags.mismatch;
    assign idle_warn_o = flags.idle_low;

    rsp_par_log #(.STAT_W(STAT_W), .CNT_W(CNT_W)) u_log (
        .clk    (clk),
        .rst_n  (rst_n),
        .err_i  (err_o),
        .code_i (cur_code),
        .clr_i  (clr_i),
        .code_q (err_code_o),
        .cnt_q  (err_cnt_o)
    );

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&stat_n_q) |-> !err_o);

    p_warn_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && idle_warn_o));

    p_clean_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (err_code_o == '0 && err_cnt_o == '0 && !err_o && !idle_warn_o));

endmodule

// File: tb/rsp_par_checker_tb_top.sv
// Scoreboard bench: the driver pushes the expected outcome of each driven
// cycle; the monitor pops and compares just after the edge that produces it.
module rsp_par_checker_tb_top;

    localparam int SW = 3;
    localparam int CW = 4;

    typedef struct {
        logic          e;
        logic          w;
        logic [SW-1:0] code;
        logic [CW-1:0] cnt;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] stat_n = '1;
    logic          par = 1'b1;
    logic          clr = 1'b0;
    logic          err, warn;
    logic [SW-1:0] code;
    logic [CW-1:0] cnt;

    int total = 0;
    int bad   = 0;
    item_t q[$];

    // Bench-side model of the record
    logic [SW-1:0] m_code = '0;
    logic [CW-1:0] m_cnt  = '0;
    logic          p_err  = 1'b0;
    logic [SW-1:0] p_code = '0;

    always #2.5 clk = ~clk;

    rsp_par_checker #(.STAT_W(SW), .CNT_W(CW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_n_i    (stat_n),
        .par_i       (par),
        .clr_i       (clr),
        .err_o       (err),
        .idle_warn_o (warn),
        .err_code_o  (code),
        .err_cnt_o   (cnt)
    );

    function automatic logic good_par(input logic [SW-1:0] l);
        int lows = 0;
        for (int i = 0; i < SW; i++) if (!l[i]) lows++;
        return (lows % 2) == 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [SW-1:0] l, input logic p, input logic c,
                         input string tag);
        item_t it;
        logic present;
        @(negedge clk);
        stat_n = l; par = p; clr = c;
        // record state after the coming edge: previous error, this clear
        if (p_err && (m_code == '0 || c)) m_code = p_code;
        else if (c)                       m_code = '0;
        if (p_err && m_cnt != '1)         m_cnt = m_cnt + 1'b1;
        present = (l != '1);
        it.e    = present && (p != good_par(l));
        it.w    = !present && !p;
        it.code = m_code;
        it.cnt  = m_cnt;
        it.tag  = tag;
        q.push_back(it);
        p_err  = it.e;
        p_code = ~l;
    endtask

    // Monitor: compare just after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check({it.tag, " err_o"},       err,  it.e);
            check({it.tag, " idle_warn_o"}, warn, it.w);
            check({it.tag, " err_code_o"},  code, it.code);
            check({it.tag, " err_cnt_o"},   cnt,  it.cnt);
        end
    end

    task automatic drain();
        drive('1, 1'b1, 1'b0, "drain");
        drive('1, 1'b1, 1'b0, "drain");
        while (q.size() > 0) @(posedge clk);
        #2;
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 err_o", err, 0);
        check("R1 idle_warn_o", warn, 0);
        check("R1 err_code_o", code, 0);
        check("R1 err_cnt_o", cnt, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every pattern with correct parity, no error
        for (int v = 0; v < 8; v++) drive(SW'(v), good_par(SW'(v)), 1'b0, "R2");
        // R4/R5: idle with parity low warns but never errors
        drive('1, 1'b0, 1'b0, "R4 R5");
        drive('1, 1'b0, 1'b0, "R4 R5");
        // R3/R6: wrong parity on every response pattern; first code held
        for (int v = 6; v >= 0; v--) drive(SW'(v), ~good_par(SW'(v)), 1'b0, "R3 R6");
        drive('1, 1'b1, 1'b0, "R3");
        // R7: clear with no error empties the record
        drive('1, 1'b1, 1'b1, "R7");
        drive('1, 1'b1, 1'b0, "R7");
        // R6: load into an empty record, then a second error leaves it alone
        drive(3'b101, 1'b1, 1'b0, "R6");
        drive(3'b011, 1'b1, 1'b0, "R6");
        drive('1, 1'b1, 1'b0, "R6");
        // R7: clear in the cycle where err_o is high loads the new code
        drive(3'b110, 1'b1, 1'b0, "R7");
        drive('1, 1'b1, 1'b1, "R7");
        drive('1, 1'b1, 1'b0, "R7");
        // R8: burst of errors drives the counter into saturation
        for (int k = 0; k < 12; k++) drive(3'b000, 1'b1, 1'b0, "R8");
        drain();
        check("R8 saturated err_cnt_o", cnt, 15);

        // R9: reset in mid-run clears the record
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 err_code_o", code, 0);
        check("R9 err_cnt_o", cnt, 0);
        rst_n = 1'b1;
        m_code = '0; m_cnt = '0; p_err = 1'b0;
        drive(3'b100, 1'b1, 1'b0, "R9 R3");
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule